// File: doc/BRIEF.md
# Shared Waveform Table Bus Sequencer

This block lets two waveform lookups share one narrow external table. The transmit side looks up an 8-bit DAC sample from a 12-bit address made of the recent history of sent bits and a sample index. The receive side looks up an 8-bit feedback sample from a 12-bit address supplied by the clock-recovery logic. The 12-bit addresses go out as two 6-bit slices, and the 8-bit samples come back as two 4-bit nibbles. A fixed four-phase rotation on the master clock decides which lookup owns the bus in each cycle.

The master clock runs at 64 times the data rate, so one four-phase round lasts one tick of the 16x transmit clock. A data bit spans 16 rounds. Each round gives one receive sample, and every four rounds give one transmit sample. A static configuration input selects whether the table answers in the same cycle or one cycle later. Each DAC output register takes its new word in a single clock, so a downstream converter never sees a word that holds one new half and one old half.

Top module: `wavetab_mux`

## Requirements
- R1: `tbl_phase` steps 0,1,2,3,0,... once per clock, starting at 0 in the first cycle after reset. Phase 0 is transmit low, 1 is transmit high, 2 is receive low and 3 is receive high.
- R2: The transmit address is {history[9:0], sample index[1:0]}, with the newest bit at address bit 2. The sample index is round count bits 3:2, and the round count advances after each phase 3. `tbl_addr` carries address bits 5:0 in phase 0 and bits 11:6 in phase 1.
- R3: `rx_addr` is sampled at the clock edge that ends phase 1. `tbl_addr` then carries its bits 5:0 in phase 2 and bits 11:6 in phase 3.
- R4: `bit_tick` is high only in phase 3 of round 15. At that edge `tx_data` is shifted into the history.
- R5: When `lat_one` is 0, the nibble for a phase is taken from `tbl_data` at the edge that ends that phase. When `lat_one` is 1, it is taken at the edge that ends the following cycle.
- R6: The low-phase nibble forms DAC bits 3:0 and the high-phase nibble forms bits 7:4.
- R7: Each DAC output changes only at the edge that takes its high nibble, and it loads both halves at once. The new transmit word appears in phase (2+lat) mod 4. The new receive word appears in phase lat.
- R8: Reset gives both DACs 0x80, phase 0, round 0, an all-zero history and an all-zero held receive address.
- R9: When `lat_one` is 1, nothing is taken in the first cycle after reset, so `rx_dac` stays 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 64x data rate |
| rst | input | 1 | Synchronous active-high reset |
| lat_one | input | 1 | Table reply latency: 0 = same cycle, 1 = next cycle (static) |
| tx_data | input | 1 | Next bit to transmit, taken when `bit_tick` is high |
| bit_tick | output | 1 | Marks the cycle whose edge takes `tx_data` |
| rx_addr | input | 12 | Receive lookup address from clock recovery |
| tbl_addr | output | 6 | Address slice on the shared table bus |
| tbl_phase | output | 2 | Current bus phase |
| tbl_data | input | 4 | Nibble returned by the table |
| tx_dac | output | 8 | Transmit waveform DAC word |
| rx_dac | output | 8 | Receive feedback DAC word |

## Verification
With a one-cycle reply, the receive high nibble arrives during the transmit-low phase of the next round. The same cycle can also hold the round wrap and, at the end of a bit, the history shift. The bench runs both latency settings with random bits and random receive addresses, plus all-ones and alternating patterns. It answers every request from an address-keyed table model, delayed where the latency calls for it. Every cycle it compares the address slice and both DAC words against its own round and history model, so a nibble taken in the wrong phase, or a word that changes outside its commit cycle, shows up as a mismatch.

// File: rtl/wavetab_pkg.sv
package wavetab_pkg;

    typedef enum logic [1:0] {
        PH_TX_LO = 2'd0,
        PH_TX_HI = 2'd1,
        PH_RX_LO = 2'd2,
        PH_RX_HI = 2'd3
    } phase_e;

    localparam int NUM_LANES = 2;

    // which phase a returning nibble belongs to, and whether to take it
    typedef struct packed {
        logic   en;
        phase_e ph;
    } reply_t;

    function automatic phase_e phase_next(input phase_e p);
        return phase_e'(p + 2'd1);
    endfunction

    function automatic phase_e reply_phase(input phase_e p, input logic lat);
        return phase_e'(p - {1'b0, lat});
    endfunction

endpackage

// File: rtl/wavetab_seq.sv
module wavetab_seq
    import wavetab_pkg::*;
#(
    parameter int RND_PER_BIT = 16,
    parameter int RW          = 4
) (
    input  logic          clk,
    input  logic          rst,
    output phase_e        ph,
    output logic [RW-1:0] rnd,
    output logic          bit_end,
    output logic          primed
);

    localparam logic [RW-1:0] RND_LAST = RW'(RND_PER_BIT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_TX_LO;
            rnd    <= '0;
            primed <= 1'b0;
        end else begin
            ph     <= phase_next(ph);
            primed <= 1'b1;
            if (ph == PH_RX_HI) begin
                rnd <= (rnd == RND_LAST) ? '0 : rnd + 1'b1;
            end
        end
    end

    always_comb begin
        bit_end = (ph == PH_RX_HI) && (rnd == RND_LAST);
    end

    // R1: strict rotation while running
    assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ph == phase_next($past(ph)));

endmodule

// File: rtl/wavetab_hist.sv
module wavetab_hist #(
    parameter int HIST_W = 10,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_end,
    input  logic                    tx_data,
    input  logic [IDX_W-1:0]        idx,
    output logic [HIST_W+IDX_W-1:0] tx_addr
);

    logic [HIST_W-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (bit_end) begin
            hist <= {hist[HIST_W-2:0], tx_data};
        end
    end

    always_comb begin
        tx_addr = {hist, idx};
    end

    // R4: the bit taken at the end of a bit period becomes the newest history bit
    assert_hist_shift_R4: assert property (@(posedge clk) disable iff (rst)
        bit_end |=> tx_addr[IDX_W] == $past(tx_data));

endmodule

// File: rtl/wavetab_lane.sv
module wavetab_lane
    import wavetab_pkg::*;
#(
    parameter int     NIB_W = 4,
    parameter phase_e LO_PH = PH_TX_LO,
    parameter phase_e HI_PH = PH_TX_HI
) (
    input  logic               clk,
    input  logic               rst,
    input  reply_t             rep,
    input  logic [NIB_W-1:0]   nib,
    output logic [2*NIB_W-1:0] dac
);

    localparam int DAC_W = 2 * NIB_W;
    localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

    logic [NIB_W-1:0] lo_stage;
    logic             lo_take;
    logic             hi_take;

    always_comb begin
        lo_take = rep.en && (rep.ph == LO_PH);
        hi_take = rep.en && (rep.ph == HI_PH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_stage <= '0;
            dac      <= MID;
        end else begin
            if (lo_take) begin
                lo_stage <= nib;
            end
            if (hi_take) begin
                dac <= {nib, lo_stage};
            end
        end
    end

    // R7: output word only moves at the high-nibble take
    assert_dac_atomic_R7: assert property (@(posedge clk) disable iff (rst)
        (dac != $past(dac)) |-> $past(hi_take));

    // R6: upper half of a fresh word is the nibble taken with it
    assert_dac_upper_R6: assert property (@(posedge clk) disable iff (rst)
        hi_take |=> dac[DAC_W-1:NIB_W] == $past(nib));

endmodule

// File: rtl/wavetab_mux.sv
module wavetab_mux
    import wavetab_pkg::*;
#(
    parameter int SLICE_W = 6,
    parameter int NIB_W   = 4,
    parameter int TX_SPB  = 4,
    parameter int RX_SPB  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lat_one,
    input  logic                 tx_data,
    output logic                 bit_tick,
    input  logic [2*SLICE_W-1:0] rx_addr,
    output logic [SLICE_W-1:0]   tbl_addr,
    output logic [1:0]           tbl_phase,
    input  logic [NIB_W-1:0]     tbl_data,
    output logic [2*NIB_W-1:0]   tx_dac,
    output logic [2*NIB_W-1:0]   rx_dac
);

    localparam int ADDR_W = 2 * SLICE_W;
    localparam int DAC_W  = 2 * NIB_W;
    localparam int IDX_W  = $clog2(TX_SPB);
    localparam int HIST_W = ADDR_W - IDX_W;
    localparam int RW     = $clog2(RX_SPB);
    localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

    phase_e            ph;
    logic [RW-1:0]     rnd;
    logic              bit_end;
    logic              primed;
    logic [ADDR_W-1:0] tx_addr;
    logic [ADDR_W-1:0] rx_q;
    reply_t            rep;
    logic [DAC_W-1:0]  lane_dac [NUM_LANES];

    wavetab_seq #(
        .RND_PER_BIT (RX_SPB),
        .RW          (RW)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .ph      (ph),
        .rnd     (rnd),
        .bit_end (bit_end),
        .primed  (primed)
    );

    wavetab_hist #(
        .HIST_W (HIST_W),
        .IDX_W  (IDX_W)
    ) u_hist (
        .clk     (clk),
        .rst     (rst),
        .bit_end (bit_end),
        .tx_data (tx_data),
        .idx     (rnd[RW-1 -: IDX_W]),
        .tx_addr (tx_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else if (ph == PH_TX_HI) begin
            rx_q <= rx_addr;
        end
    end

    always_comb begin
        unique case (ph)
            PH_TX_LO: tbl_addr = tx_addr[SLICE_W-1:0];
            PH_TX_HI: tbl_addr = tx_addr[ADDR_W-1:SLICE_W];
            PH_RX_LO: tbl_addr = rx_q[SLICE_W-1:0];
            default:  tbl_addr = rx_q[ADDR_W-1:SLICE_W];
        endcase
        rep.en    = !lat_one || primed;
        rep.ph    = reply_phase(ph, lat_one);
        tbl_phase = ph;
        bit_tick  = bit_end;
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        wavetab_lane #(
            .NIB_W (NIB_W),
            .LO_PH (phase_e'(2 * g)),
            .HI_PH (phase_e'(2 * g + 1))
        ) u_lane (
            .clk (clk),
            .rst (rst),
            .rep (rep),
            .nib (tbl_data),
            .dac (lane_dac[g])
        );
    end

    assign tx_dac = lane_dac[0];
    assign rx_dac = lane_dac[1];

    // R4: a bit boundary is always followed by a fresh round at transmit low
    assert_tick_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> tbl_phase == 2'd0);

    // R9: with a late reply nothing stale reaches the receive DAC
    assert_no_stale_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && lat_one) |=> rx_dac == MID);

endmodule

// File: tb/sim_wavetab_mux.sv
module sim_wavetab_mux;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lat_one = 1'b0;
    logic        tx_data = 1'b0;
    logic        bit_tick;
    logic [11:0] rx_addr = '0;
    logic [5:0]  tbl_addr;
    logic [1:0]  tbl_phase;
    logic [3:0]  tbl_data = '0;
    logic [7:0]  tx_dac;
    logic [7:0]  rx_dac;

    always #2.5 clk = ~clk;

    wavetab_mux u0 (
        .clk       (clk),
        .rst       (rst),
        .lat_one   (lat_one),
        .tx_data   (tx_data),
        .bit_tick  (bit_tick),
        .rx_addr   (rx_addr),
        .tbl_addr  (tbl_addr),
        .tbl_phase (tbl_phase),
        .tbl_data  (tbl_data),
        .tx_dac    (tx_dac),
        .rx_dac    (rx_dac)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    int         m_ph, m_rnd, mode;
    logic       lat;
    logic [9:0] m_hist;
    logic [11:0] m_rxq;
    logic [3:0] resp [4];
    bit         vld  [4];
    logic [7:0] e_tx, e_rx;
    logic [3:0] pend, salt;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog R1 actual=%0d cycles expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [3:0] tf(input int p, input logic [5:0] a, input logic [3:0] s);
        return 4'((a[3:0] ^ {a[5:4], a[1:0]}) + 4'(p * 3) + s);
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic step();
        logic [11:0] txa;
        logic [5:0]  ea;
        logic [11:0] nrx;
        logic        nb;
        bit          tick;
        txa = {m_hist, 2'(m_rnd >> 2)};
        chk(tbl_phase == 2'(m_ph), "R1 phase", tbl_phase, m_ph);
        case (m_ph)
            0:       ea = txa[5:0];
            1:       ea = txa[11:6];
            2:       ea = m_rxq[5:0];
            default: ea = m_rxq[11:6];
        endcase
        chk(tbl_addr == ea, (m_ph < 2) ? "R2 tx address slice" : "R3 rx address slice",
            tbl_addr, ea);
        tick = (m_ph == 3) && (m_rnd == 15);
        chk(bit_tick == tick, "R4 bit tick", bit_tick, tick);
        // R5 R6 R7: commit visibility phases depend on latency
        if (m_ph == (2 + lat) % 4 && vld[0] && vld[1]) e_tx = {resp[1], resp[0]};
        if (m_ph == lat && vld[2] && vld[3]) e_rx = {resp[3], resp[2]};
        chk(tx_dac == e_tx, "R7 tx dac word (R5 R6)", tx_dac, e_tx);
        chk(rx_dac == e_rx, "R7 rx dac word (R5 R6)", rx_dac, e_rx);
        resp[m_ph] = tf(m_ph, tbl_addr, salt);
        vld[m_ph]  = 1'b1;
        if (!lat) begin
            tbl_data = resp[m_ph];
        end else begin
            tbl_data = pend;
            pend     = resp[m_ph];
        end
        nrx = (mode == 1) ? 12'hFFF : 12'($urandom);
        rx_addr = nrx;
        if (m_ph == 1) m_rxq = nrx;
        if (mode == 1)      nb = 1'b1;
        else if (mode == 2) nb = ~m_hist[0];
        else                nb = 1'($urandom);
        tx_data = nb;
        if (tick) m_hist = {m_hist[8:0], nb};
        if (m_ph == 3) m_rnd = (m_rnd + 1) % 16;
        m_ph = (m_ph + 1) % 4;
    endtask

    task automatic run(input logic l, input int m, input int n, input logic [3:0] s);
        @(negedge clk);
        rst = 1'b1; lat_one = l; lat = l; mode = m; salt = s;
        tbl_data = '0; pend = '0;
        repeat (2) @(negedge clk);
        chk(tx_dac == 8'h80, "R8 tx dac reset", tx_dac, 8'h80);
        chk(rx_dac == 8'h80, "R8 rx dac reset", rx_dac, 8'h80);
        chk(tbl_phase == 2'd0, "R8 phase reset", tbl_phase, 0);
        chk(tbl_addr == 6'd0, "R8 history reset", tbl_addr, 0);
        m_ph = 0; m_rnd = 0; m_hist = '0; m_rxq = '0;
        for (int k = 0; k < 4; k++) vld[k] = 1'b0;
        e_tx = 8'h80; e_rx = 8'h80;
        rst = 1'b0;
        for (int i = 0; i < n; i++) begin
            step();
            @(negedge clk);
            if (i == 0 && l) chk(rx_dac == 8'h80, "R9 no stale capture", rx_dac, 8'h80);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run(1'b0, 0, 1500, 4'd3);
        run(1'b1, 0, 1500, 4'd9);
        run(1'b0, 1, 300, 4'd0);
        run(1'b1, 2, 400, 4'd15);
        run(1'b1, 1, 200, 4'd5);
        run(1'b0, 2, 200, 4'd12);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule